// File: doc/BRIEF.md
# ADC Result Window Comparator with Match Counting

This block watches the stream of finished conversion results from an analog-to-digital converter. It has two compare units, and each is set up on its own. A unit looks only at results tagged with its programmed channel. It tests each such result against a 10-bit threshold, using either "below the threshold" or "at or above the threshold".

A unit does not flag on the first qualifying result. It keeps a run counter of qualifying results on its channel. It raises a sticky flag once the run reaches the programmed match number plus one. A result on its channel that fails the test ends the run. Each flag is cleared by writing a one to its status bit. A single interrupt output is active while any flag is set whose unit has its interrupt enabled.

Software writes one 32-bit configuration word per unit and a status word for flag clearing. The converter supplies a load strobe together with the result and its channel number.

Top module: `adc_window_cmp`

## Requirements
- R1: After reset both flags and the interrupt are 0 and both units are disabled, so no load can set a flag until a unit is configured.
- R2: A unit evaluates a load only when its enable (config bit 0) is 1 and the load's channel equals its channel field (config bits 5:3). Loads on other channels leave its run counter and flag unchanged.
- R3: Condition bit (config bit 2) = 0 qualifies results strictly below the threshold (config bits 25:16). Condition bit = 1 qualifies results greater than or equal to the threshold.
- R4: The flag of a unit becomes 1 on the clock edge that takes the (M+1)-th consecutive qualifying result of its channel, where M is config bits 11:8 (0..15). It is visible in the cycle after the load strobe.
- R5: A result of the unit's channel that does not qualify returns the run counter to zero.
- R6: When the flag sets, the run counter restarts from zero, so the next flag needs another M+1 qualifying results.
- R7: While a unit is disabled its run counter is held at zero.
- R8: Writing status with bit 1 (unit 0) or bit 2 (unit 1) set clears that flag on the next edge. Zero bits have no effect. A flag set by a load in the same cycle as its clear stays 1. Flags are otherwise sticky.
- R9: The interrupt output is 1 exactly when some unit has its flag at 1 and its interrupt enable (config bit 1) at 1.
- R10: The two units are independent; configuration writes go to unit `cfg_sel` only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_stb | input | 1 | New conversion result loaded |
| ld_res | input | 10 | Loaded conversion result |
| ld_ch | input | 3 | Channel of the loaded result |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | Unit addressed by the configuration write |
| cfg_wdata | input | 32 | Configuration word |
| stat_we | input | 1 | Status write strobe (write-one-to-clear) |
| stat_wdata | input | 32 | Status word; bit 1 clears unit 0, bit 2 clears unit 1 |
| cmp_flag | output | 2 | Sticky compare flags, one per unit |
| cmp_irq | output | 1 | Compare interrupt request |

## Verification
The sweep covers both conditions and several match counts, including 0 and 15. Its thresholds sit at 0, 1, the midpoint and full scale. Results straddle each threshold by two codes, which separates a less-than test from a less-or-equal one. Loads rotate across four channels, so results on foreign channels must leave a run intact while failing results on the unit's own channel must break it. Periodic flag clears, some in the same cycle as a setting load, are also mixed in. Directed sequences then isolate exact-threshold boundaries, run reset by a failure, restart after a flag, reset on disable, set-over-clear priority, and interrupt gating.

// File: rtl/adc_cmp_pkg.sv
`timescale 1ns/1ps
package adc_cmp_pkg;
    localparam int RES_W   = 10;
    localparam int CH_W    = 3;
    localparam int MC_W    = 4;
    localparam int N_UNITS = 2;
    localparam int DATA_W  = 32;
    localparam int SEL_W   = (N_UNITS > 1) ? $clog2(N_UNITS) : 1;

    localparam int EN_BIT   = 0;
    localparam int IE_BIT   = 1;
    localparam int COND_BIT = 2;
    localparam int CH_LSB   = 3;
    localparam int MC_LSB   = 8;
    localparam int THR_LSB  = 16;
    localparam int FLAG_LSB = 1;

    typedef enum logic {
        COND_LT = 1'b0,
        COND_GE = 1'b1
    } cmp_cond_e;

    typedef struct packed {
        logic [RES_W-1:0] thr;
        logic [MC_W-1:0]  mcnt;
        logic [CH_W-1:0]  ch;
        cmp_cond_e        cond;
        logic             ie;
        logic             en;
    } cmp_cfg_t;

    function automatic cmp_cfg_t unpack_cfg(input logic [DATA_W-1:0] w);
        cmp_cfg_t c;
        c.en   = w[EN_BIT];
        c.ie   = w[IE_BIT];
        c.cond = cmp_cond_e'(w[COND_BIT]);
        c.ch   = w[CH_LSB +: CH_W];
        c.mcnt = w[MC_LSB +: MC_W];
        c.thr  = w[THR_LSB +: RES_W];
        return c;
    endfunction

    function automatic logic cond_hit(input cmp_cond_e c,
                                      input logic [RES_W-1:0] res,
                                      input logic [RES_W-1:0] thr);
        return (c == COND_GE) ? (res >= thr) : (res < thr);
    endfunction
endpackage

// File: rtl/adc_cmp_cfgreg.sv
`timescale 1ns/1ps
module adc_cmp_cfgreg
    import adc_cmp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [DATA_W-1:0] wdata,
    output cmp_cfg_t          cfg
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= '0;
        end else if (we) begin
            cfg <= unpack_cfg(wdata);
        end
    end
endmodule

// File: rtl/adc_cmp_unit.sv
`timescale 1ns/1ps
module adc_cmp_unit
    import adc_cmp_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  cmp_cfg_t         cfg,
    input  logic             ld_stb,
    input  logic [RES_W-1:0] ld_res,
    input  logic [CH_W-1:0]  ld_ch,
    input  logic             clr,
    output logic             flag
);
    logic [MC_W-1:0] run_cnt;
    logic            sel_load;
    logic            hit;
    logic            reach;
    logic            set_now;

    assign sel_load = cfg.en && ld_stb && (ld_ch == cfg.ch);
    assign hit      = cond_hit(cfg.cond, ld_res, cfg.thr);
    assign reach    = (run_cnt == cfg.mcnt);
    assign set_now  = sel_load && hit && reach;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_cnt <= '0;
            flag    <= 1'b0;
        end else begin
            if (!cfg.en) begin
                run_cnt <= '0;
            end else if (sel_load) begin
                if (!hit || reach) begin
                    run_cnt <= '0;
                end else begin
                    run_cnt <= run_cnt + 1'b1;
                end
            end
            flag <= set_now || (flag && !clr);
        end
    end
endmodule

// File: rtl/adc_window_cmp.sv
`timescale 1ns/1ps
module adc_window_cmp
    import adc_cmp_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               ld_stb,
    input  logic [RES_W-1:0]   ld_res,
    input  logic [CH_W-1:0]    ld_ch,
    input  logic               cfg_we,
    input  logic [SEL_W-1:0]   cfg_sel,
    input  logic [DATA_W-1:0]  cfg_wdata,
    input  logic               stat_we,
    input  logic [DATA_W-1:0]  stat_wdata,
    output logic [N_UNITS-1:0] cmp_flag,
    output logic               cmp_irq
);
    logic [N_UNITS-1:0] ie_vec;

    for (genvar u = 0; u < N_UNITS; u++) begin : g_unit
        cmp_cfg_t cfg_q;
        logic     clr;

        assign clr       = stat_we && stat_wdata[FLAG_LSB + u];
        assign ie_vec[u] = cfg_q.ie;

        adc_cmp_cfgreg u_cfg (
            .clk   (clk),
            .rst   (rst),
            .we    (cfg_we && (cfg_sel == SEL_W'(u))),
            .wdata (cfg_wdata),
            .cfg   (cfg_q)
        );

        adc_cmp_unit u_cmp (
            .clk    (clk),
            .rst    (rst),
            .cfg    (cfg_q),
            .ld_stb (ld_stb),
            .ld_res (ld_res),
            .ld_ch  (ld_ch),
            .clr    (clr),
            .flag   (cmp_flag[u])
        );
    end

    assign cmp_irq = |(cmp_flag & ie_vec);
endmodule

// File: rtl/adc_window_cmp_chk.sv
`timescale 1ns/1ps
module adc_window_cmp_chk
    import adc_cmp_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               ld_stb,
    input logic               stat_we,
    input logic [N_UNITS-1:0] clr_bits,
    input logic [N_UNITS-1:0] cmp_flag,
    input logic               cmp_irq
);
    // R1
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (cmp_flag == '0) && !cmp_irq);

    // R9
    irq_needs_flag_chk: assert property (@(posedge clk) disable iff (rst)
        cmp_irq |-> (cmp_flag != '0));

    for (genvar u = 0; u < N_UNITS; u++) begin : g_u
        // R8
        clear_takes_chk: assert property (@(posedge clk) disable iff (rst)
            (stat_we && clr_bits[u] && !ld_stb) |=> !cmp_flag[u]);
        // R8
        flag_sticky_chk: assert property (@(posedge clk) disable iff (rst)
            (cmp_flag[u] && !(stat_we && clr_bits[u])) |=> cmp_flag[u]);
        // R4
        set_needs_load_chk: assert property (@(posedge clk) disable iff (rst)
            (!cmp_flag[u] && !ld_stb) |=> !cmp_flag[u]);
    end
endmodule

bind adc_window_cmp adc_window_cmp_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .ld_stb   (ld_stb),
    .stat_we  (stat_we),
    .clr_bits (stat_wdata[adc_cmp_pkg::N_UNITS:1]),
    .cmp_flag (cmp_flag),
    .cmp_irq  (cmp_irq)
);

// File: tb/adc_window_cmp_tb.sv
`timescale 1ns/1ps
module adc_window_cmp_tb;
    logic        clk = 1'b0;
    logic        rst;
    logic        ld_stb;
    logic [9:0]  ld_res;
    logic [2:0]  ld_ch;
    logic        cfg_we;
    logic [0:0]  cfg_sel;
    logic [31:0] cfg_wdata;
    logic        stat_we;
    logic [31:0] stat_wdata;
    logic [1:0]  cmp_flag;
    logic        cmp_irq;

    int vectors = 0;
    int errors  = 0;

    logic [31:0] m_cfg  [2];
    int          m_cnt  [2];
    bit          m_flag [2];

    always #2.5 clk = ~clk;

    adc_window_cmp u_dut (
        .clk(clk), .rst(rst), .ld_stb(ld_stb), .ld_res(ld_res), .ld_ch(ld_ch),
        .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .stat_we(stat_we), .stat_wdata(stat_wdata),
        .cmp_flag(cmp_flag), .cmp_irq(cmp_irq)
    );

    function automatic logic [31:0] mk(bit en, bit ie, bit cond, int ch, int mc, int thr);
        logic [31:0] w = '0;
        w[0] = en; w[1] = ie; w[2] = cond;
        w[5:3] = ch[2:0]; w[11:8] = mc[3:0]; w[25:16] = thr[9:0];
        return w;
    endfunction

    task automatic chk(string tag, int act, int exp);
        vectors++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic cycle(string tag, bit do_cfg, int sel, logic [31:0] cd,
                         bit do_ld, int res, int ch, bit do_st, logic [31:0] sd);
        bit setf, hit;
        int exp_irq;
        cfg_we = do_cfg; cfg_sel = sel[0]; cfg_wdata = cd;
        ld_stb = do_ld; ld_res = res[9:0]; ld_ch = ch[2:0];
        stat_we = do_st; stat_wdata = sd;
        @(posedge clk);
        for (int u = 0; u < 2; u++) begin
            setf = 0;
            hit = m_cfg[u][2] ? (res >= int'(m_cfg[u][25:16])) : (res < int'(m_cfg[u][25:16]));
            if (!m_cfg[u][0]) m_cnt[u] = 0;
            else if (do_ld && ch == int'(m_cfg[u][5:3])) begin
                if (!hit) m_cnt[u] = 0;
                else if (m_cnt[u] == int'(m_cfg[u][11:8])) begin setf = 1; m_cnt[u] = 0; end
                else m_cnt[u]++;
            end
            m_flag[u] = setf | (m_flag[u] & !(do_st && sd[1+u]));
        end
        if (do_cfg) m_cfg[sel] = cd;
        @(negedge clk);
        cfg_we = 0; ld_stb = 0; stat_we = 0;
        exp_irq = int'((m_flag[0] & m_cfg[0][1]) | (m_flag[1] & m_cfg[1][1]));
        chk(tag, int'(cmp_flag[0]), int'(m_flag[0]));
        chk(tag, int'(cmp_flag[1]), int'(m_flag[1]));
        chk(tag, int'(cmp_irq), exp_irq);
    endtask

    task automatic cfg(int u, logic [31:0] w); cycle("R10", 1, u, w, 0, 0, 0, 0, 0); endtask
    task automatic ld(string tag, int res, int ch); cycle(tag, 0, 0, 0, 1, res, ch, 0, 0); endtask
    task automatic clr(string tag, logic [31:0] d); cycle(tag, 0, 0, 0, 0, 0, 0, 1, d); endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        int thr_list [4] = '{0, 1, 512, 1023};
        int mc_list  [4] = '{0, 2, 5, 15};
        int res;
        for (int u = 0; u < 2; u++) begin m_cfg[u] = 0; m_cnt[u] = 0; m_flag[u] = 0; end
        rst = 1; ld_stb = 0; ld_res = 0; ld_ch = 0; cfg_we = 0; cfg_sel = 0;
        cfg_wdata = 0; stat_we = 0; stat_wdata = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0;
        // R1: reset state, and a disabled unit ignores loads
        chk("R1", int'(cmp_flag), 0);
        chk("R1", int'(cmp_irq), 0);
        ld("R1", 0, 0);
        ld("R1", 0, 0);
        chk("R1", int'(cmp_flag), 0);

        // R3: boundary at threshold, less-than
        cfg(0, mk(1, 1, 0, 0, 0, 100));
        ld("R3", 100, 0); chk("R3", int'(cmp_flag[0]), 0);
        ld("R3", 99, 0);  chk("R3", int'(cmp_flag[0]), 1);
        clr("R8", 32'h2); chk("R8", int'(cmp_flag[0]), 0);
        // R3: greater-or-equal
        cfg(0, mk(1, 1, 1, 0, 0, 100));
        ld("R3", 99, 0);  chk("R3", int'(cmp_flag[0]), 0);
        ld("R3", 100, 0); chk("R3", int'(cmp_flag[0]), 1);
        clr("R8", 32'h2);

        // R2: foreign channels do not touch the run
        cfg(0, mk(1, 0, 1, 2, 1, 500));
        ld("R2", 600, 2); ld("R2", 10, 5); ld("R2", 10, 3);
        chk("R2", int'(cmp_flag[0]), 0);
        ld("R2", 600, 2); chk("R2", int'(cmp_flag[0]), 1);
        chk("R9", int'(cmp_irq), 0);
        cfg(0, mk(1, 1, 1, 2, 1, 500));
        chk("R9", int'(cmp_irq), 1);
        clr("R8", 32'h2);

        // R5: failing result on own channel restarts the run
        cfg(0, mk(1, 1, 1, 2, 2, 500));
        ld("R5", 600, 2); ld("R5", 600, 2); ld("R5", 100, 2);
        ld("R5", 600, 2); ld("R5", 600, 2);
        chk("R5", int'(cmp_flag[0]), 0);
        ld("R5", 600, 2); chk("R5", int'(cmp_flag[0]), 1);

        // R6: restart after flag set
        clr("R8", 32'h2);
        cfg(0, mk(1, 1, 1, 2, 1, 0));
        ld("R6", 7, 2); ld("R6", 7, 2); chk("R6", int'(cmp_flag[0]), 1);
        clr("R6", 32'h2);
        ld("R6", 7, 2); chk("R6", int'(cmp_flag[0]), 0);
        ld("R6", 7, 2); chk("R6", int'(cmp_flag[0]), 1);
        clr("R8", 32'h2);

        // R7: disabling clears the run
        ld("R7", 7, 2);
        cfg(0, mk(0, 1, 1, 2, 1, 0));
        cfg(0, mk(1, 1, 1, 2, 1, 0));
        ld("R7", 7, 2); chk("R7", int'(cmp_flag[0]), 0);
        ld("R7", 7, 2); chk("R7", int'(cmp_flag[0]), 1);

        // R8: zero bits and other unit's bit do not clear; set beats clear
        clr("R8", 32'h0);  chk("R8", int'(cmp_flag[0]), 1);
        clr("R8", 32'h4);  chk("R8", int'(cmp_flag[0]), 1);
        clr("R8", 32'h2);  chk("R8", int'(cmp_flag[0]), 0);
        ld("R8", 7, 2);
        cycle("R8", 0, 0, 0, 1, 7, 2, 1, 32'h2);
        chk("R8", int'(cmp_flag[0]), 1);
        clr("R8", 32'h6);

        // R4/R10: sweep over conditions, thresholds, match counts
        for (int cnd = 0; cnd < 2; cnd++)
            for (int ti = 0; ti < 4; ti++)
                for (int mi = 0; mi < 4; mi++) begin
                    cfg(0, 0); cfg(1, 0);
                    clr("R8", 32'h6);
                    cfg(0, mk(1, cnd[0], cnd[0], 1, mc_list[mi], thr_list[ti]));
                    cfg(1, mk(1, 1, !cnd[0], 2, (mc_list[mi] + 1) % 16, 1023 - thr_list[ti]));
                    for (int k = 0; k < 48; k++) begin
                        if (k % 3 == 0) res = (k * 97 + thr_list[ti]) % 1024;
                        else res = thr_list[ti] + (k % 5) - 2;
                        if (res < 0) res = 0;
                        if (res > 1023) res = 1023;
                        if (k % 11 == 10) res = 1023 - res;
                        cycle("R4", 0, 0, 0, 1, res, k % 4, (k % 7 == 6), 32'h6);
                    end
                end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule